// File: doc/BRIEF.md
# DRAM ECC Error Log

This block sits next to the ECC checker of a DRAM controller and keeps a record of the most important memory error seen since software last acknowledged it. The checker raises a one-cycle correctable or uncorrectable event together with the failing address, an 8-bit syndrome and the channel that returned the data. The block turns these events into sticky status flags. It holds one logged record made of a 4 KiB block address, a syndrome and a channel. It can also raise a one-cycle system-error pulse for each cause that software has enabled.

Software reaches the block through a simple register port. There is a status word whose flags are cleared by writing ones, a command word holding the two signalling enables, and read-only address, syndrome and channel words. An uncorrectable error takes over a record that holds a correctable one. The reverse never happens. A handler that reads the status, then the record, then the status again can therefore see when an uncorrectable error landed between its reads, and trust the second record.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `sys_err` is low.
- R2: A correctable event sets status bit 0 and an uncorrectable event sets status bit 7, visible from the cycle after the event. All other status bits read zero.
- R3: Writing the status word clears each flag whose bit (0 or 7) is written as 1. Flags written as 0 keep their value.
- R4: The address word (index 2) returns bits 31:12 of the logged failing address in place, and bits 11:0 read as zero.
- R5: The syndrome word (index 3) returns the 8-bit logged syndrome in bits 7:0. The channel word (index 4) returns the logged channel in bit 0. All higher bits of both read as zero.
- R6: An uncorrectable event that finds the uncorrectable flag clear loads address, syndrome and channel, even when a correctable record is present.
- R7: A correctable event loads the record only when both flags are clear. While the correctable flag is set, later correctable events leave the record unchanged.
- R8: While the uncorrectable flag is set, no event of either kind changes the record.
- R9: In the command word (index 1) only bit 7 (correctable enable) and bit 8 (uncorrectable enable) are stored. Every other bit reads zero.
- R10: `sys_err` is high for one cycle, in the cycle the flag first reads set, when a flag goes from clear to set and its enable is 1. An event on a flag that is already set, or on a disabled cause, gives no pulse.
- R11: When a clearing write and a new event of the same cause arrive in the same cycle, the flag stays set.
- R12: `reg_rdata` shows the word selected by `reg_addr` one cycle later (index 0 status, 1 command, 2 address, 3 syndrome, 4 channel). Indices 5 to 7 read zero.
- R13: Correctable and uncorrectable events in the same cycle set both flags and log the fields carried with them as an uncorrectable record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_evt | input | 1 | Correctable error event pulse |
| ue_evt | input | 1 | Uncorrectable error event pulse |
| evt_addr | input | 32 | Failing physical address of the event |
| evt_syn | input | 8 | ECC syndrome of the event |
| evt_chan | input | 1 | Channel that saw the event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| sys_err | output | 1 | One-cycle system-error pulse |

## Verification
The bench goes after the priority corners. In one case an uncorrectable event lands on a correctable record: a design with the priority inverted would keep the stale address, and software would report the wrong location. In others, correctable or uncorrectable events arrive while a record is held: a design that logs every event would move the address under software's feet. The bench also drives a clearing write and a new event in the same cycle, where a design giving the write priority would lose the error. It checks that the pulse appears only on a clear-to-set change of an enabled cause: a level-based or unmasked output would fire repeatedly or when disabled. Finally it tries partial clears, writes of zero, and simultaneous events of both kinds.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_AW    = 3;
  localparam int NUM_CAUSE = 2;
  localparam int CAUSE_CE  = 0;
  localparam int CAUSE_UE  = 1;

  localparam logic [REG_AW-1:0] RA_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] RA_CMD    = 3'd1;
  localparam logic [REG_AW-1:0] RA_ADDR   = 3'd2;
  localparam logic [REG_AW-1:0] RA_SYN    = 3'd3;
  localparam logic [REG_AW-1:0] RA_CHAN   = 3'd4;

  // status bit of each cause; software depends on these positions
  function automatic int sts_bit(input int cause);
    return (cause == CAUSE_UE) ? 7 : 0;
  endfunction

  // command enable bit of each cause
  function automatic int en_bit(input int cause);
    return (cause == CAUSE_UE) ? 8 : 7;
  endfunction
endpackage

// File: rtl/ecc_log_flags.sv
module ecc_log_flags #(
  parameter int NUM_CAUSE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CAUSE-1:0] evt,
  input  logic [NUM_CAUSE-1:0] clr,
  output logic [NUM_CAUSE-1:0] flag,
  output logic [NUM_CAUSE-1:0] rise
);
  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    // a new event beats a clearing write in the same cycle
    always_ff @(posedge clk) begin
      if (rst)          flag[g] <= 1'b0;
      else if (evt[g])  flag[g] <= 1'b1;
      else if (clr[g])  flag[g] <= 1'b0;
    end
    assign rise[g] = evt[g] && !flag[g];
  end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int SYN_W    = 8,
  parameter int CHAN_W   = 1,
  localparam int BLK_W   = ADDR_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic              ce_flag,
  input  logic              ue_flag,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic [CHAN_W-1:0] evt_chan,
  output logic [BLK_W-1:0]  log_blk,
  output logic [SYN_W-1:0]  log_syn,
  output logic [CHAN_W-1:0] log_chan
);
  logic take_ue, take_ce, load;
  logic unused_addr_lsb;

  // uncorrectable takes over a correctable record; nothing displaces it
  assign take_ue = ue_evt && !ue_flag;
  assign take_ce = ce_evt && !ce_flag && !ue_flag;
  assign load    = take_ue || take_ce;
  assign unused_addr_lsb = ^evt_addr[PAGE_LSB-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      log_blk  <= '0;
      log_syn  <= '0;
      log_chan <= '0;
    end else if (load) begin
      log_blk  <= evt_addr[ADDR_W-1:PAGE_LSB];
      log_syn  <= evt_syn;
      log_chan <= evt_chan;
    end
  end
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs #(
  parameter int NUM_CAUSE = 2,
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 12,
  parameter int SYN_W     = 8,
  parameter int CHAN_W    = 1,
  parameter int DATA_W    = 32,
  localparam int BLK_W    = ADDR_W - PAGE_LSB,
  localparam int AW       = ecc_log_pkg::REG_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [NUM_CAUSE-1:0] flag,
  input  logic [NUM_CAUSE-1:0] rise,
  input  logic [BLK_W-1:0]     log_blk,
  input  logic [SYN_W-1:0]     log_syn,
  input  logic [CHAN_W-1:0]    log_chan,
  output logic [NUM_CAUSE-1:0] cmd_en,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 sys_err
);
  import ecc_log_pkg::*;

  logic [DATA_W-1:0] sts_word, cmd_word, addr_word, syn_word, chan_word;
  logic [DATA_W-1:0] rd_mux;
  logic              cmd_wr;
  logic              unused_wdata;

  assign cmd_wr       = reg_wr && (reg_addr == RA_CMD);
  assign unused_wdata = ^reg_wdata;

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_en
    localparam int EB = en_bit(g);
    always_ff @(posedge clk) begin
      if (rst)         cmd_en[g] <= 1'b0;
      else if (cmd_wr) cmd_en[g] <= reg_wdata[EB];
    end
  end

  always_comb begin
    sts_word = '0;
    cmd_word = '0;
    for (int c = 0; c < NUM_CAUSE; c++) begin
      sts_word[sts_bit(c)] = flag[c];
      cmd_word[en_bit(c)]  = cmd_en[c];
    end
    addr_word = '0;
    addr_word[ADDR_W-1:PAGE_LSB] = log_blk;
    syn_word  = '0;
    syn_word[SYN_W-1:0] = log_syn;
    chan_word = '0;
    chan_word[CHAN_W-1:0] = log_chan;
  end

  always_comb begin
    case (reg_addr)
      RA_STATUS: rd_mux = sts_word;
      RA_CMD:    rd_mux = cmd_word;
      RA_ADDR:   rd_mux = addr_word;
      RA_SYN:    rd_mux = syn_word;
      RA_CHAN:   rd_mux = chan_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      sys_err   <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      sys_err   <= |(rise & cmd_en);
    end
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int SYN_W    = 8,
  parameter int NUM_CHAN = 2,
  parameter int DATA_W   = 32,
  localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int BLK_W   = ADDR_W - PAGE_LSB,
  localparam int AW      = ecc_log_pkg::REG_AW,
  localparam int NC      = ecc_log_pkg::NUM_CAUSE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic [CHAN_W-1:0] evt_chan,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_err
);
  import ecc_log_pkg::*;

  logic [NC-1:0]     evt_vec, clr_vec, flag_vec, rise_vec, cmd_en;
  logic              sts_wr, ce_flag, ue_flag;
  logic [BLK_W-1:0]  log_blk;
  logic [SYN_W-1:0]  log_syn;
  logic [CHAN_W-1:0] log_chan;

  assign sts_wr = reg_wr && (reg_addr == RA_STATUS);
  assign evt_vec[CAUSE_CE] = ce_evt;
  assign evt_vec[CAUSE_UE] = ue_evt;

  for (genvar g = 0; g < NC; g++) begin : g_clr
    localparam int SB = sts_bit(g);
    assign clr_vec[g] = sts_wr && reg_wdata[SB];
  end

  assign ce_flag = flag_vec[CAUSE_CE];
  assign ue_flag = flag_vec[CAUSE_UE];

  ecc_log_flags #(.NUM_CAUSE(NC)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt_vec),
    .clr  (clr_vec),
    .flag (flag_vec),
    .rise (rise_vec)
  );

  ecc_log_capture #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .SYN_W(SYN_W), .CHAN_W(CHAN_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .ce_evt   (ce_evt),
    .ue_evt   (ue_evt),
    .ce_flag  (ce_flag),
    .ue_flag  (ue_flag),
    .evt_addr (evt_addr),
    .evt_syn  (evt_syn),
    .evt_chan (evt_chan),
    .log_blk  (log_blk),
    .log_syn  (log_syn),
    .log_chan (log_chan)
  );

  ecc_log_regs #(
    .NUM_CAUSE(NC), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB),
    .SYN_W(SYN_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flag      (flag_vec),
    .rise      (rise_vec),
    .log_blk   (log_blk),
    .log_syn   (log_syn),
    .log_chan  (log_chan),
    .cmd_en    (cmd_en),
    .reg_rdata (reg_rdata),
    .sys_err   (sys_err)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int SYN_W  = 8,
  parameter int CHAN_W = 1,
  parameter int BLK_W  = 20,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ce_evt,
  input logic                          ue_evt,
  input logic [SYN_W-1:0]              evt_syn,
  input logic [CHAN_W-1:0]             evt_chan,
  input logic                          reg_wr,
  input logic [ecc_log_pkg::REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic                          sys_err,
  input logic                          ce_flag,
  input logic                          ue_flag,
  input logic [BLK_W-1:0]              log_blk,
  input logic [SYN_W-1:0]              log_syn,
  input logic [CHAN_W-1:0]             log_chan
);
  import ecc_log_pkg::*;

  logic unused_chk;
  assign unused_chk = ^reg_wdata;

  p_ce_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ce_evt |=> ce_flag);

  p_ue_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ue_evt |=> ue_flag);

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_STATUS && reg_wdata[0] && !ce_evt) |=> !ce_flag);

  p_ue_logs_r6: assert property (@(posedge clk) disable iff (rst)
    (ue_evt && !ue_flag) |=> (log_syn == $past(evt_syn) && log_chan == $past(evt_chan)));

  p_ce_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ce_flag && !ue_evt) |=> ($stable(log_blk) && $stable(log_syn) && $stable(log_chan)));

  p_ue_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ue_flag |=> ($stable(log_blk) && $stable(log_syn) && $stable(log_chan)));

  p_serr_cause_r10: assert property (@(posedge clk) disable iff (rst)
    sys_err |-> ($rose(ce_flag) || $rose(ue_flag)));

  p_evt_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (ce_evt && ce_flag) |=> ce_flag);
endmodule

bind ecc_err_log ecc_err_log_chk #(
  .SYN_W(SYN_W), .CHAN_W(CHAN_W), .BLK_W(BLK_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_evt = 1'b0, ue_evt = 1'b0;
  logic [31:0] evt_addr = '0;
  logic [7:0]  evt_syn = '0;
  logic [0:0]  evt_chan = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_err;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ecc_err_log dut (
    .clk(clk), .rst(rst), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_err(sys_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // drives one event cycle, returns sys_err in the next two cycles
  task automatic fire(input logic ce, input logic ue, input logic [31:0] a,
                      input logic [7:0] s, input logic ch,
                      output logic p0, output logic p1);
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s; evt_chan = ch;
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0; p0 = sys_err;
    @(negedge clk); p1 = sys_err;
  endtask

  task automatic expect_log(input string req, input logic [31:0] sts,
                            input logic [31:0] a, input logic [31:0] s,
                            input logic [31:0] ch);
    logic [31:0] d;
    rd(3'd0, d); chk(req, "status", d, sts);
    rd(3'd2, d); chk(req, "address", d, a);
    rd(3'd3, d); chk(req, "syndrome", d, s);
    rd(3'd4, d); chk(req, "channel", d, ch);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(i[2:0], d); chk("R1", $sformatf("reg %0d after reset", i), d, 0);
    end
    chk("R1", "sys_err after reset", {31'd0, sys_err}, 0);
  endtask

  task automatic t_ce_log;
    logic p0, p1;
    wr(3'd1, 32'h0000_0080);
    fire(1, 0, 32'h1234_5ABC, 8'h5A, 1, p0, p1);
    chk("R10", "ce pulse", {31'd0, p0}, 1);
    chk("R10", "ce pulse one cycle", {31'd0, p1}, 0);
    expect_log("R2 R4 R5", 32'h1, 32'h1234_5000, 32'h5A, 32'h1);
    fire(1, 0, 32'hAAAA_A777, 8'h11, 0, p0, p1);
    chk("R10", "no pulse on set flag", {31'd0, p0}, 0);
    expect_log("R7", 32'h1, 32'h1234_5000, 32'h5A, 32'h1);
  endtask

  task automatic t_ue_over;
    logic p0, p1;
    fire(0, 1, 32'hFEDC_B123, 8'hC3, 0, p0, p1);
    chk("R10", "ue disabled no pulse", {31'd0, p0}, 0);
    expect_log("R6", 32'h81, 32'hFEDC_B000, 32'hC3, 32'h0);
    fire(1, 1, 32'h0000_1FFF, 8'h01, 1, p0, p1);
    expect_log("R8", 32'h81, 32'hFEDC_B000, 32'hC3, 32'h0);
    wr(3'd0, 32'h0000_0001);
    expect_log("R3 partial clear", 32'h80, 32'hFEDC_B000, 32'hC3, 32'h0);
    fire(1, 0, 32'h5555_5000, 8'h77, 1, p0, p1);
    expect_log("R8 ce under ue", 32'h81, 32'hFEDC_B000, 32'hC3, 32'h0);
    wr(3'd0, 32'h0000_0000);
    expect_log("R3 zero write", 32'h81, 32'hFEDC_B000, 32'hC3, 32'h0);
    wr(3'd0, 32'h0000_0081);
    expect_log("R3 full clear", 32'h0, 32'hFEDC_B000, 32'hC3, 32'h0);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R9", "command all ones", d, 32'h0000_0180);
    wr(3'd1, 32'h0000_FE7F);
    rd(3'd1, d); chk("R9", "command no enables", d, 32'h0);
    wr(3'd1, 32'h0000_0100);
    rd(3'd1, d); chk("R9", "command ue only", d, 32'h0000_0100);
  endtask

  task automatic t_ue_pulse;
    logic p0, p1;
    fire(1, 0, 32'h0101_0FFF, 8'h22, 0, p0, p1);
    chk("R10", "ce disabled no pulse", {31'd0, p0}, 0);
    fire(0, 1, 32'h8000_0000, 8'hE1, 1, p0, p1);
    chk("R10", "ue pulse", {31'd0, p0}, 1);
    chk("R10", "ue pulse one cycle", {31'd0, p1}, 0);
    expect_log("R6", 32'h81, 32'h8000_0000, 32'hE1, 32'h1);
    wr(3'd0, 32'h0000_0081);
  endtask

  task automatic t_both;
    logic p0, p1;
    wr(3'd1, 32'h0000_0180);
    fire(1, 1, 32'h3C3C_3C3C, 8'h99, 1, p0, p1);
    chk("R10", "pulse on both", {31'd0, p0}, 1);
    expect_log("R13", 32'h81, 32'h3C3C_3000, 32'h99, 32'h1);
    wr(3'd0, 32'h0000_0081);
  endtask

  task automatic t_race;
    logic [31:0] d;
    logic p0;
    logic p1;
    fire(1, 0, 32'h0000_2000, 8'h10, 0, p0, p1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1;
    ce_evt = 1'b1; evt_addr = 32'h0000_3000; evt_syn = 8'h20; evt_chan = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ce_evt = 1'b0; p0 = sys_err;
    chk("R11", "no pulse on held flag", {31'd0, p0}, 0);
    rd(3'd0, d); chk("R11", "flag survives clear", d, 32'h1);
    rd(3'd2, d); chk("R11", "record kept", d, 32'h0000_2000);
    wr(3'd0, 32'h1);
    fire(1, 0, 32'h0000_4000, 8'h40, 1, p0, p1);
    expect_log("R7 reload after clear", 32'h1, 32'h0000_4000, 32'h40, 32'h1);
  endtask

  task automatic t_map;
    logic [31:0] d;
    for (int i = 5; i < 8; i++) begin
      rd(i[2:0], d); chk("R12", $sformatf("unmapped %0d", i), d, 0);
    end
    @(negedge clk); reg_addr = 3'd3;
    @(negedge clk); reg_addr = 3'd0;
    chk("R12", "syndrome after one cycle", reg_rdata, 32'h40);
    @(negedge clk);
    chk("R12", "status follows", reg_rdata, 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ce_log();
    t_ue_over();
    t_cmd();
    t_ue_pulse();
    t_both();
    t_race();
    t_map();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule